// File: doc/BRIEF.md
# External-Clock Synchronized Event Counter

An 8-bit up-counter that advances either on a tick from an external prescaler or on edges seen at an asynchronous input pin. The pin has no timing relation to the system clock. It first passes a capture stage on the falling system-clock edge, then a synchronizing flop, then a registered edge detector. An edge therefore reaches the count 2.5 to 3.5 system clocks after it arrives at the pin. Pin edges never go through the prescaler: each detected edge gives exactly one count step.

A mode input picks the count sequence. In the plain sequence the counter wraps from 0xFF to 0x00. In clear-on-match mode it returns to zero on the step taken while it equals a compare value. A sticky overflow flag records every step taken at 0xFF.

A one-address-bit register port writes the count or clears the flag. The same port reads back either value.

Top module: `ext_event_counter`

## Requirements
- R1: After reset the count is 0x00 and the overflow flag is 0.
- R2: With clock select 2'b00 (stopped) the count never changes except by a register write.
- R3: With clock select 2'b01 the count advances by exactly one on every clock in which the prescaler tick is high. Pin activity is ignored in this mode.
- R4: With clock select 2'b10 each rising pin edge advances the count exactly once. An edge that arrives in the high phase of the clock shows at the third rising clock edge after it. One that arrives in the low phase shows at the fourth.
- R5: With clock select 2'b11 each falling pin edge advances the count exactly once, with the same latency as R4.
- R6: In both pin modes the prescaler tick has no effect. Pulses whose high and low phases each last at least two clocks are all counted.
- R7: With the mode input low, a step taken at 0xFF gives 0x00.
- R8: With the mode input high, a step taken while the count equals the compare input gives 0x00. Otherwise the step adds one.
- R9: A step taken at 0xFF sets the overflow flag. The flag stays set until it is cleared.
- R10: Writing with address 1 and data bit 0 set clears the flag. Data bit 0 clear leaves it alone. A set in the same cycle wins over the clear.
- R11: A write with address 0 loads the count. It blocks any step in that cycle, so there is no increment and no flag set.
- R12: Read data is the count at address 0. At address 1 it is the flag in bit 0 with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 1 | Asynchronous external event pin |
| preTick | input | 1 | One-cycle tick from the prescaler |
| clkSel | input | 2 | Count source: 0 stopped, 1 tick, 2 pin rising, 3 pin falling |
| ctcMode | input | 1 | 1 selects clear-on-match, 0 selects wrap at 0xFF |
| cmpVal | input | 8 | Compare value for clear-on-match |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register address: 0 count, 1 flag |
| regWdata | input | 8 | Register write data |
| count | output | 8 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |
| regRdata | output | 8 | Register read data selected by regAddr |

## Verification
The bench changes the pin at fixed offsets inside the high phase and inside the low phase of the clock. It checks that the count holds through the second rising edge and steps at the third, or through the third and steps at the fourth. A chain with a missing or extra stage would step one clock early or late. Pulse trains of random width check that every edge counts once and that the prescaler tick is ignored in pin modes; a detector that fired on both edges or let the tick through would count too many. A random run with a bench model covers the wrap and the compare match, and so does a directed case at 0xFF: a design that cleared one clock late, or cleared on the wrong value, would drift from the model. It also covers a load in the same cycle as a step, and a flag clear in the same cycle as a set. There, a design that gave the step priority, or let the clear win, would show a wrong count or flag.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_TICK = 2'b01,
    SRC_RISE = 2'b10,
    SRC_FALL = 2'b11
  } clkSrc_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic countEn;  // take one count step
    logic loadCnt;  // load count from write data
    logic clrFlag;  // clear overflow flag
  } evcStrobe_t;
endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       preTick,
  input  logic [1:0] clkSel,
  input  logic       regWe,
  input  logic       regAddr,
  input  logic       wrBit0,
  output evcStrobe_t st
);
  logic pinCap, pinSync, pinPrev;
  logic riseQ, fallQ;
  clkSrc_e src;

  // half-cycle capture of the asynchronous pin
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) pinCap <= 1'b0;
    else       pinCap <= pinIn;
  end

  // synchronizer, history and registered edge pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= 1'b0;
      pinPrev <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
    end else begin
      pinSync <= pinCap;
      pinPrev <= pinSync;
      riseQ   <= pinSync & ~pinPrev;
      fallQ   <= ~pinSync & pinPrev;
    end
  end

  assign src = clkSrc_e'(clkSel);

  always_comb begin
    st = '0;
    unique case (src)
      SRC_OFF:  st.countEn = 1'b0;
      SRC_TICK: st.countEn = preTick;
      SRC_RISE: st.countEn = riseQ;
      SRC_FALL: st.countEn = fallQ;
      default:  st.countEn = 1'b0;
    endcase
    st.loadCnt = regWe & ~regAddr;
    st.clrFlag = regWe & regAddr & wrBit0;
  end
endmodule

// File: rtl/evc_dpath.sv
module evc_dpath
  import evc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  evcStrobe_t   st,
  input  logic         ctcMode,
  input  logic [W-1:0] cmpVal,
  input  logic [W-1:0] regWdata,
  input  logic         regAddr,
  output logic [W-1:0] count,
  output logic         ovfFlag,
  output logic [W-1:0] regRdata
);
  localparam logic [W-1:0] MAXV = '1;

  logic atMax, atCmp, stepTaken;

  assign atMax     = (count == MAXV);
  assign atCmp     = ctcMode && (count == cmpVal);
  assign stepTaken = st.countEn && !st.loadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (st.loadCnt)      count <= regWdata;
      else if (st.countEn) count <= atCmp ? '0 : count + 1'b1;

      if (stepTaken && atMax) ovfFlag <= 1'b1;
      else if (st.clrFlag)    ovfFlag <= 1'b0;
    end
  end

  assign regRdata = regAddr ? {{(W-1){1'b0}}, ovfFlag} : count;
endmodule

// File: rtl/ext_event_counter.sv
module ext_event_counter
  import evc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinIn,
  input  logic         preTick,
  input  logic [1:0]   clkSel,
  input  logic         ctcMode,
  input  logic [W-1:0] cmpVal,
  input  logic         regWe,
  input  logic         regAddr,
  input  logic [W-1:0] regWdata,
  output logic [W-1:0] count,
  output logic         ovfFlag,
  output logic [W-1:0] regRdata
);
  evcStrobe_t st;

  evc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .preTick(preTick),
    .clkSel(clkSel), .regWe(regWe), .regAddr(regAddr),
    .wrBit0(regWdata[0]), .st(st)
  );

  evc_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .ctcMode(ctcMode), .cmpVal(cmpVal),
    .regWdata(regWdata), .regAddr(regAddr), .count(count),
    .ovfFlag(ovfFlag), .regRdata(regRdata)
  );
endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   clkSel,
  input logic         ctcMode,
  input logic [W-1:0] cmpVal,
  input logic         regWe,
  input logic         regAddr,
  input logic [W-1:0] regWdata,
  input logic [W-1:0] count,
  input logic         ovfFlag
);
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regAddr) |=> (count == $past(regWdata)));

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 2'b00 && !(regWe && !regAddr)) |=> $stable(count));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && !regAddr) |=>
      ($stable(count) || count == W'($past(count) + 1'b1) || count == '0));

  a_r8_match_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctcMode && count == cmpVal && !(regWe && !regAddr)) |=>
      (count == '0 || $stable(count)));

  a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (count == '1 && !(regWe && !regAddr)) |=> ($stable(count) || ovfFlag));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(regWe && regAddr && regWdata[0])) |=> ovfFlag);

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && regWe && regAddr && regWdata[0] && count != '1) |=> !ovfFlag);
endmodule

bind ext_event_counter evc_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .clkSel(clkSel), .ctcMode(ctcMode),
  .cmpVal(cmpVal), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .count(count), .ovfFlag(ovfFlag)
);

// File: tb/sim_ext_event_counter.sv
module sim_ext_event_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIn = 1'b0;
  logic       preTick = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       ctcMode = 1'b0;
  logic [7:0] cmpVal = 8'h00;
  logic       regWe = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] count, regRdata;
  logic       ovfFlag;

  int nChk = 0;
  int nBad = 0;
  logic [7:0] mCount = 8'h00;
  logic       mFlag = 1'b0;
  bit done = 0;

  ext_event_counter u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .preTick(preTick), .clkSel(clkSel),
    .ctcMode(ctcMode), .cmpVal(cmpVal), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .count(count), .ovfFlag(ovfFlag), .regRdata(regRdata)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  function automatic logic [7:0] nxtCnt(logic [7:0] c, bit en, bit we, bit a,
                                        logic [7:0] wd, bit ctc, logic [7:0] cmp);
    if (we && !a) return wd;             // R11
    if (en) begin
      if (ctc && c == cmp) return 8'h00; // R8
      return c + 8'h01;                  // R3, R7
    end
    return c;
  endfunction

  function automatic bit nxtFlag(bit f, logic [7:0] c, bit en, bit we, bit a,
                                 logic [7:0] wd);
    bit setF, clrF;
    setF = en && !(we && !a) && (c == 8'hFF); // R9
    clrF = we && a && wd[0];                  // R10
    return setF | (f & ~clrF);
  endfunction

  // one clock step driven at the falling edge, checked 2 ns after the rising edge
  task automatic cyc(string req, bit tick, bit we, bit a, logic [7:0] wd);
    logic [7:0] nC;
    bit nF, en;
    @(negedge clk);
    preTick = tick; regWe = we; regAddr = a; regWdata = wd;
    en = (clkSel == 2'b01) && tick;
    nC = nxtCnt(mCount, en, we, a, wd, ctcMode, cmpVal);
    nF = nxtFlag(mFlag, mCount, en, we, a, wd);
    @(posedge clk); #2;
    mCount = nC; mFlag = nF;
    chk(req, count, mCount);
    chk(req, {7'b0, ovfFlag}, {7'b0, mFlag});
    preTick = 1'b0; regWe = 1'b0;
  endtask

  // one pin pulse, edges 5 ns after a rising clock edge (high phase)
  task automatic pulse(int hiC, int loC);
    @(posedge clk); #5 pinIn = 1'b1;
    repeat (hiC) @(posedge clk);
    #5 pinIn = 1'b0;
    repeat (loC - 1) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (3) @(posedge clk);
    #2; chk("R1 count after reset", count, 8'h00);
    chk("R1 flag after reset", {7'b0, ovfFlag}, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1 count out of reset", count, 8'h00);

    // R2: stopped source ignores ticks
    clkSel = 2'b00;
    for (int i = 0; i < 5; i++) cyc("R2 stopped", 1'b1, 1'b0, 1'b0, 8'h00);

    // R3, R7, R9: wrap at 0xFF
    clkSel = 2'b01;
    cyc("R11 load", 1'b0, 1'b1, 1'b0, 8'hFE);
    cyc("R3 step", 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R3 value FF", count, 8'hFF);
    cyc("R7 wrap", 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R7 wrap to 00", count, 8'h00);
    chk("R9 flag set", {7'b0, ovfFlag}, 8'h01);
    cyc("R9 sticky", 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 flag stays", {7'b0, ovfFlag}, 8'h01);

    // R12: read port
    @(negedge clk); regAddr = 1'b1; #1;
    chk("R12 read flag", regRdata, 8'h01);
    regAddr = 1'b0; #1;
    chk("R12 read count", regRdata, count);

    // R10: write 0 keeps flag, write 1 clears it
    cyc("R10 write zero", 1'b0, 1'b1, 1'b1, 8'hFE);
    chk("R10 flag kept", {7'b0, ovfFlag}, 8'h01);
    cyc("R10 clear", 1'b0, 1'b1, 1'b1, 8'h01);
    chk("R10 flag cleared", {7'b0, ovfFlag}, 8'h00);

    // R10: set beats clear in the same cycle
    cyc("R11 load FF", 1'b0, 1'b1, 1'b0, 8'hFF);
    cyc("R10 set wins", 1'b1, 1'b1, 1'b1, 8'h01);
    chk("R10 set wins flag", {7'b0, ovfFlag}, 8'h01);
    cyc("R10 clear", 1'b0, 1'b1, 1'b1, 8'h01);

    // R11: load with tick at FF, no increment, no flag
    cyc("R11 load FF", 1'b0, 1'b1, 1'b0, 8'hFF);
    cyc("R11 load beats step", 1'b1, 1'b1, 1'b0, 8'h40);
    chk("R11 loaded value", count, 8'h40);
    chk("R11 no flag", {7'b0, ovfFlag}, 8'h00);

    // R8: clear on match
    ctcMode = 1'b1; cmpVal = 8'h05;
    cyc("R11 load", 1'b0, 1'b1, 1'b0, 8'h04);
    cyc("R8 step to match", 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R8 at compare", count, 8'h05);
    cyc("R8 clear", 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R8 cleared", count, 8'h00);
    chk("R8 no flag below max", {7'b0, ovfFlag}, 8'h00);

    // random run on the tick source
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) ctcMode = $urandom_range(0, 1);
      if (r < 3) cmpVal = $urandom_range(0, 255);
      if (r >= 95) clkSel = $urandom_range(0, 1);
      if (r < 4)
        cyc("R11 random load", $urandom_range(0, 1), 1'b1, 1'b0, 8'($urandom_range(0, 255)));
      else if (r < 7)
        cyc("R10 random clear", $urandom_range(0, 1), 1'b1, 1'b1, 8'($urandom_range(0, 255)));
      else
        cyc("R3 random step", ($urandom_range(0, 3) != 0), 1'b0, 1'b0, 8'h00);
    end

    // R4, R6: rising pin edges, tick held high and ignored
    ctcMode = 1'b0;
    clkSel = 2'b10;
    cyc("R11 load", 1'b0, 1'b1, 1'b0, 8'h00);
    cyc("R10 clear", 1'b0, 1'b1, 1'b1, 8'h01);
    preTick = 1'b1;
    for (int i = 0; i < 20; i++) pulse($urandom_range(2, 5), $urandom_range(2, 5));
    repeat (6) @(posedge clk); #2;
    chk("R4 R6 rising count", count, 8'd20);

    // R5, R6: falling edges, switched while pin is stable low
    @(negedge clk); clkSel = 2'b11; preTick = 1'b1;
    for (int i = 0; i < 15; i++) pulse($urandom_range(2, 5), $urandom_range(2, 5));
    repeat (6) @(posedge clk); #2;
    chk("R5 R6 falling count", count, 8'd35);
    preTick = 1'b0;

    // R4 latency: rise in high phase shows at third rising edge
    @(negedge clk); clkSel = 2'b10;
    repeat (3) @(posedge clk);
    @(posedge clk); #5 pinIn = 1'b1;
    repeat (2) @(posedge clk); #2;
    chk("R4 hold at second edge", count, 8'd35);
    @(posedge clk); #2;
    chk("R4 step at third edge", count, 8'd36);

    // R5 latency: fall in low phase shows at fourth rising edge
    repeat (3) @(posedge clk);
    @(negedge clk); clkSel = 2'b11;
    repeat (2) @(posedge clk);
    @(posedge clk); #15 pinIn = 1'b0;
    repeat (3) @(posedge clk); #2;
    chk("R5 hold at third edge", count, 8'd36);
    @(posedge clk); #2;
    chk("R5 step at fourth edge", count, 8'd37);

    // R3: tick mode ignores the pin
    repeat (3) @(posedge clk);
    @(negedge clk); clkSel = 2'b01;
    pulse(3, 3);
    repeat (6) @(posedge clk); #2;
    chk("R3 pin ignored", count, 8'd37);

    finishRun();
  end
endmodule